// File: doc/BRIEF.md
# Associative Register Rename Unit

This block sits in the issue stage of an out-of-order integer core. It gives every issued instruction that writes a register a fresh entry in a separate rename register file, which sits beside a 32-entry architectural register file. For each source operand it answers one question: is the operand already available, and with what value, or which rename entry will produce it. Each rename entry records the architectural register it stands for, a data word, a produced flag and a "newest mapping" flag. Up to `LANES` instructions are renamed per cycle, in program order.

Execution results arrive on a write-back port. Retirement then either commits an entry, which copies its value into the architectural file and frees it, or cancels it, which discards the value and frees it. Entries held by wrong-path instructions are released only when retirement cancels them one by one, so architectural state stays precise.

In the default associative mode, one architectural register may have several live rename entries at once. A static mode input switches to indexed operation, where each architectural register has at most one live rename.

Top module: `rn_rename_unit`

## Requirements
- R1: After synchronous reset, no rename entry is live. `iss_full` and every `ren_valid` bit are 0, and every architectural register reads as 0.
- R2: Each accepted lane with a destination gets the lowest-numbered free rename entry. Lanes are served in ascending order, and no two live mappings share a tag.
- R3: One cycle after acceptance, `ren_valid` is set, and each source is reported as follows. If the newest live mapping has produced its value, the source reads rdy=1 with that value. If that mapping is still pending, the source reads rdy=0 with the producing tag. If there is no live mapping, the source reads rdy=1 with the architectural value. Tag is 0 when ready, and value is 0 when not ready.
- R4: A source naming the destination of an earlier lane in the same group takes that lane's new tag, with rdy=0.
- R5: In associative mode (`indexed_mode`=0), a second destination write to an architectural register that already has a live mapping is accepted. Later lookups of that register then resolve to the newest mapping.
- R6: A write-back marks its entry produced and stores the data. A lookup in the same cycle as the write-back already sees rdy=1 with that data.
- R7: A commit copies the entry's value into the architectural register and frees the entry. If the freed entry was the newest mapping, later lookups fall back to the architectural register.
- R8: A cancel frees the entry and leaves the architectural file unchanged. If the cancelled entry was the newest mapping, the mapping it replaced becomes newest again, provided that mapping is still live. Otherwise lookups fall back to the architectural register.
- R9: In indexed mode (`indexed_mode`=1, held steady while mappings are live), a destination whose register already has a live mapping stalls. A destination that repeats an earlier lane's destination in the same group also stalls.
- R10: When no free entry remains for a lane, that lane and every later lane are refused, and `iss_full` is 1 in the same cycle. `iss_take` is always a prefix of the lanes.
- R11: In a cycle with a cancel, no lane is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| indexed_mode | input | 1 | 1 selects one mapping per architectural register |
| iss_valid | input | LANES | Lane holds an instruction |
| iss_has_dst | input | LANES | Lane writes a destination register |
| iss_dst | input | LANES x 5 | Destination architectural register |
| iss_src_a | input | LANES x 5 | First source register |
| iss_src_b | input | LANES x 5 | Second source register |
| iss_take | output | LANES | Lane accepted this cycle (combinational) |
| iss_full | output | 1 | A lane was refused for lack of a free entry (combinational) |
| ren_valid | output | LANES | Rename result valid (one cycle after acceptance) |
| ren_dst_tag | output | LANES x TW | Rename entry given to the destination |
| ren_a_rdy | output | LANES | First source available |
| ren_a_tag | output | LANES x TW | Producing tag of first source when not ready |
| ren_a_val | output | LANES x DW | Value of first source when ready |
| ren_b_rdy | output | LANES | Second source available |
| ren_b_tag | output | LANES x TW | Producing tag of second source when not ready |
| ren_b_val | output | LANES x DW | Value of second source when ready |
| wb_valid | input | 1 | Execution result write |
| wb_tag | input | TW | Entry receiving the result |
| wb_data | input | DW | Result value |
| cmt_valid | input | 1 | Commit one entry |
| cmt_tag | input | TW | Entry to commit |
| cxl_valid | input | 1 | Cancel one entry |
| cxl_tag | input | TW | Entry to cancel |

## Verification
A stale or missing newest-mapping flag does not stay hidden. It shows up on the next lookup of that register, one cycle after issue, as a wrong producing tag or as an architectural value returned in place of a pending one. A broken free-entry picker shows up at once, as a duplicated or out-of-order `ren_dst_tag` or as `iss_full` rising while entries are still free. Damage to the restore-on-cancel path stays latent until a register with two live mappings loses the newer one. For that reason, the stimulus cancels youngest-first across such pairs and then looks the register up after each cancel.

// File: rtl/rn_pkg.sv
package rn_pkg;
  localparam int ARCH_REGS = 32;
  localparam int AW        = $clog2(ARCH_REGS);
  localparam int OPNDS     = 2;
endpackage

// File: rtl/rn_free_pick.sv
module rn_free_pick #(
  parameter int ENTRIES = 8,
  parameter int PICKS   = 2,
  localparam int TW     = $clog2(ENTRIES)
) (
  input  logic [ENTRIES-1:0]          busy,
  output logic [PICKS-1:0][TW-1:0]    pick_tag,
  output logic [PICKS-1:0]            pick_ok
);
  // k-th lowest free entry for k = 0 .. PICKS-1
  always_comb begin
    logic [ENTRIES-1:0] used;
    used = busy;
    for (int k = 0; k < PICKS; k++) begin
      pick_ok[k]  = 1'b0;
      pick_tag[k] = '0;
      for (int e = 0; e < ENTRIES; e++) begin
        if (!pick_ok[k] && !used[e]) begin
          pick_ok[k]  = 1'b1;
          pick_tag[k] = TW'(e);
        end
      end
      if (pick_ok[k]) used[pick_tag[k]] = 1'b1;
    end
  end
endmodule

// File: rtl/rn_cam.sv
module rn_cam #(
  parameter int ENTRIES = 8,
  parameter int TW      = 3,
  parameter int AW      = 5
) (
  input  logic [AW-1:0]               key,
  input  logic [ENTRIES-1:0]          busy,
  input  logic [ENTRIES-1:0]          latest,
  input  logic [ENTRIES-1:0][AW-1:0]  arch,
  output logic                        hit,
  output logic [TW-1:0]               tag
);
  // newest live mapping of one architectural register
  always_comb begin
    hit = 1'b0;
    tag = '0;
    for (int e = 0; e < ENTRIES; e++) begin
      if (busy[e] && latest[e] && arch[e] == key) begin
        hit = 1'b1;
        tag = TW'(e);
      end
    end
  end
endmodule

// File: rtl/rn_rename_unit.sv
module rn_rename_unit #(
  parameter int LANES   = 2,
  parameter int ENTRIES = 8,
  parameter int DW      = 32,
  localparam int TW     = $clog2(ENTRIES),
  localparam int AW     = rn_pkg::AW
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        indexed_mode,
  input  logic [LANES-1:0]            iss_valid,
  input  logic [LANES-1:0]            iss_has_dst,
  input  logic [LANES-1:0][AW-1:0]    iss_dst,
  input  logic [LANES-1:0][AW-1:0]    iss_src_a,
  input  logic [LANES-1:0][AW-1:0]    iss_src_b,
  output logic [LANES-1:0]            iss_take,
  output logic                        iss_full,
  output logic [LANES-1:0]            ren_valid,
  output logic [LANES-1:0][TW-1:0]    ren_dst_tag,
  output logic [LANES-1:0]            ren_a_rdy,
  output logic [LANES-1:0][TW-1:0]    ren_a_tag,
  output logic [LANES-1:0][DW-1:0]    ren_a_val,
  output logic [LANES-1:0]            ren_b_rdy,
  output logic [LANES-1:0][TW-1:0]    ren_b_tag,
  output logic [LANES-1:0][DW-1:0]    ren_b_val,
  input  logic                        wb_valid,
  input  logic [TW-1:0]               wb_tag,
  input  logic [DW-1:0]               wb_data,
  input  logic                        cmt_valid,
  input  logic [TW-1:0]               cmt_tag,
  input  logic                        cxl_valid,
  input  logic [TW-1:0]               cxl_tag
);
  localparam int NOP = rn_pkg::OPNDS;

  // rename entry state
  logic [ENTRIES-1:0]          ent_busy, ent_valid, ent_latest, ent_prev_ok;
  logic [ENTRIES-1:0][AW-1:0]  ent_arch;
  logic [ENTRIES-1:0][TW-1:0]  ent_prev;
  logic [DW-1:0]               ent_data [ENTRIES];
  logic [DW-1:0]               arch_rf  [rn_pkg::ARCH_REGS];

  // allocation
  logic [LANES-1:0][TW-1:0]    pick_tag;
  logic [LANES-1:0]            pick_ok;
  logic [LANES-1:0]            alloc, lat_new, p_ok;
  logic [LANES-1:0][TW-1:0]    new_tag, p_tag;

  // lookups
  logic [LANES-1:0]            d_hit, a_hit, b_hit;
  logic [LANES-1:0][TW-1:0]    d_tag, a_tag, b_tag;
  logic [LANES-1:0][NOP-1:0]          res_rdy;
  logic [LANES-1:0][NOP-1:0][TW-1:0]  res_tag;
  logic [LANES-1:0][NOP-1:0][DW-1:0]  res_val;

  rn_free_pick #(.ENTRIES(ENTRIES), .PICKS(LANES)) u_pick (
    .busy(ent_busy), .pick_tag(pick_tag), .pick_ok(pick_ok)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_cam
    rn_cam #(.ENTRIES(ENTRIES), .TW(TW), .AW(AW)) u_dst (
      .key(iss_dst[g]), .busy(ent_busy), .latest(ent_latest), .arch(ent_arch),
      .hit(d_hit[g]), .tag(d_tag[g]));
    rn_cam #(.ENTRIES(ENTRIES), .TW(TW), .AW(AW)) u_sa (
      .key(iss_src_a[g]), .busy(ent_busy), .latest(ent_latest), .arch(ent_arch),
      .hit(a_hit[g]), .tag(a_tag[g]));
    rn_cam #(.ENTRIES(ENTRIES), .TW(TW), .AW(AW)) u_sb (
      .key(iss_src_b[g]), .busy(ent_busy), .latest(ent_latest), .arch(ent_arch),
      .hit(b_hit[g]), .tag(b_tag[g]));
  end

  // lane acceptance, in program order; stop at the first refused lane
  always_comb begin
    int   nxt;
    logic blocked, clash, sel_ok;
    logic [TW-1:0] sel_tag;
    nxt      = 0;
    blocked  = cxl_valid;
    iss_full = 1'b0;
    iss_take = '0;
    alloc    = '0;
    new_tag  = '0;
    for (int i = 0; i < LANES; i++) begin
      clash   = 1'b0;
      sel_ok  = 1'b0;
      sel_tag = '0;
      for (int j = 0; j < LANES; j++) begin
        if (j < i && alloc[j] && iss_dst[j] == iss_dst[i]) clash = 1'b1;
      end
      for (int k = 0; k < LANES; k++) begin
        if (k == nxt) begin
          sel_ok  = pick_ok[k];
          sel_tag = pick_tag[k];
        end
      end
      if (iss_valid[i] && !blocked) begin
        if (!iss_has_dst[i]) begin
          iss_take[i] = 1'b1;
        end else if (indexed_mode && (clash || d_hit[i])) begin
          blocked = 1'b1;
        end else if (!sel_ok) begin
          blocked  = 1'b1;
          iss_full = 1'b1;
        end else begin
          iss_take[i] = 1'b1;
          alloc[i]    = 1'b1;
          new_tag[i]  = sel_tag;
          nxt++;
        end
      end else if (iss_valid[i]) begin
        blocked = 1'b1;
      end
    end
  end

  // newest flag and replaced mapping for each new entry
  always_comb begin
    for (int i = 0; i < LANES; i++) begin
      lat_new[i] = 1'b1;
      p_ok[i]    = d_hit[i] && !(cmt_valid && cmt_tag == d_tag[i]);
      p_tag[i]   = d_tag[i];
      for (int j = 0; j < LANES; j++) begin
        if (j > i && alloc[j] && iss_dst[j] == iss_dst[i]) lat_new[i] = 1'b0;
        if (j < i && alloc[j] && iss_dst[j] == iss_dst[i]) begin
          p_ok[i]  = 1'b1;
          p_tag[i] = new_tag[j];
        end
      end
    end
  end

  // operand resolution: same group first, then rename file, then architectural file
  always_comb begin
    logic [AW-1:0] s;
    logic          h, g;
    logic [TW-1:0] t, gt;
    for (int i = 0; i < LANES; i++) begin
      for (int op = 0; op < NOP; op++) begin
        s  = (op == 0) ? iss_src_a[i] : iss_src_b[i];
        h  = (op == 0) ? a_hit[i]     : b_hit[i];
        t  = (op == 0) ? a_tag[i]     : b_tag[i];
        g  = 1'b0;
        gt = '0;
        for (int j = 0; j < LANES; j++) begin
          if (j < i && alloc[j] && iss_dst[j] == s) begin
            g  = 1'b1;
            gt = new_tag[j];
          end
        end
        res_rdy[i][op] = 1'b1;
        res_tag[i][op] = '0;
        res_val[i][op] = '0;
        if (g) begin
          res_rdy[i][op] = 1'b0;
          res_tag[i][op] = gt;
        end else if (h) begin
          if (ent_valid[t]) begin
            res_val[i][op] = ent_data[t];
          end else if (wb_valid && wb_tag == t) begin
            res_val[i][op] = wb_data;
          end else begin
            res_rdy[i][op] = 1'b0;
            res_tag[i][op] = t;
          end
        end else begin
          res_val[i][op] = arch_rf[s];
        end
      end
    end
  end

  // registered rename results
  always_ff @(posedge clk) begin
    if (rst) begin
      ren_valid   <= '0;
      ren_dst_tag <= '0;
      ren_a_rdy   <= '0;
      ren_a_tag   <= '0;
      ren_a_val   <= '0;
      ren_b_rdy   <= '0;
      ren_b_tag   <= '0;
      ren_b_val   <= '0;
    end else begin
      ren_valid   <= iss_take;
      ren_dst_tag <= new_tag;
      for (int i = 0; i < LANES; i++) begin
        ren_a_rdy[i] <= res_rdy[i][0];
        ren_a_tag[i] <= res_tag[i][0];
        ren_a_val[i] <= res_val[i][0];
        ren_b_rdy[i] <= res_rdy[i][1];
        ren_b_tag[i] <= res_tag[i][1];
        ren_b_val[i] <= res_val[i][1];
      end
    end
  end

  // entry bookkeeping: write-back, commit, cancel, then new mappings
  always_ff @(posedge clk) begin
    if (rst) begin
      ent_busy    <= '0;
      ent_valid   <= '0;
      ent_latest  <= '0;
      ent_prev_ok <= '0;
      ent_arch    <= '0;
      ent_prev    <= '0;
    end else begin
      if (wb_valid) ent_valid[wb_tag] <= 1'b1;
      if (cmt_valid) begin
        ent_busy[cmt_tag]   <= 1'b0;
        ent_valid[cmt_tag]  <= 1'b0;
        ent_latest[cmt_tag] <= 1'b0;
        for (int e = 0; e < ENTRIES; e++)
          if (ent_prev[e] == cmt_tag) ent_prev_ok[e] <= 1'b0;
      end
      if (cxl_valid) begin
        ent_busy[cxl_tag]   <= 1'b0;
        ent_valid[cxl_tag]  <= 1'b0;
        ent_latest[cxl_tag] <= 1'b0;
        if (ent_latest[cxl_tag] && ent_prev_ok[cxl_tag] && ent_busy[ent_prev[cxl_tag]])
          ent_latest[ent_prev[cxl_tag]] <= 1'b1;
        for (int e = 0; e < ENTRIES; e++)
          if (ent_prev[e] == cxl_tag) ent_prev_ok[e] <= 1'b0;
      end
      for (int i = 0; i < LANES; i++) begin
        if (alloc[i]) begin
          if (d_hit[i]) ent_latest[d_tag[i]] <= 1'b0;
          ent_busy[new_tag[i]]    <= 1'b1;
          ent_valid[new_tag[i]]   <= 1'b0;
          ent_latest[new_tag[i]]  <= lat_new[i];
          ent_arch[new_tag[i]]    <= iss_dst[i];
          ent_prev[new_tag[i]]    <= p_tag[i];
          ent_prev_ok[new_tag[i]] <= p_ok[i];
        end
      end
    end
  end

  // rename data array, no reset
  always_ff @(posedge clk) begin
    if (wb_valid) ent_data[wb_tag] <= wb_data;
  end

  // architectural file
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int r = 0; r < rn_pkg::ARCH_REGS; r++) arch_rf[r] <= '0;
    end else if (cmt_valid) begin
      arch_rf[ent_arch[cmt_tag]] <= ent_data[cmt_tag];
    end
  end

  // ---------------- assertions ----------------
  logic idx_dup;
  always_comb begin
    idx_dup = 1'b0;
    for (int x = 0; x < ENTRIES; x++)
      for (int y = 0; y < ENTRIES; y++)
        if (x < y && ent_busy[x] && ent_busy[y] && ent_arch[x] == ent_arch[y]) idx_dup = 1'b1;
  end

  a_r9_one_per_reg: assert property (@(posedge clk) disable iff (rst)
    indexed_mode |-> !idx_dup);
  a_r7_commit_live: assert property (@(posedge clk) disable iff (rst)
    cmt_valid |-> (ent_busy[cmt_tag] && ent_valid[cmt_tag]));
  a_r7_commit_frees: assert property (@(posedge clk) disable iff (rst)
    cmt_valid |=> !ent_busy[$past(cmt_tag)]);
  a_r8_cancel_frees: assert property (@(posedge clk) disable iff (rst)
    cxl_valid |=> (!ent_busy[$past(cxl_tag)] && !ent_latest[$past(cxl_tag)]));
  a_r10_take_prefix: assert property (@(posedge clk) disable iff (rst)
    ((iss_take >> 1) & ~iss_take) == '0);
  a_r10_full_refuses: assert property (@(posedge clk) disable iff (rst)
    iss_full |-> (iss_take != iss_valid));
  a_r11_cancel_holds: assert property (@(posedge clk) disable iff (rst)
    cxl_valid |-> (iss_take == '0));
  for (genvar g = 0; g < LANES; g++) begin : g_chk
    a_r2_alloc_free: assert property (@(posedge clk) disable iff (rst)
      alloc[g] |-> !ent_busy[new_tag[g]]);
    a_r3_result_follows: assert property (@(posedge clk) disable iff (rst)
      iss_take[g] |=> ren_valid[g]);
  end
endmodule

// File: tb/rn_rename_unit_tb_top.sv
module rn_rename_unit_tb_top;
  localparam int L  = 2;
  localparam int NE = 8;
  localparam int TW = 3;
  localparam int DW = 32;

  logic clk = 1'b0;
  logic rst;
  always #5 clk = ~clk;

  logic                    indexed_mode;
  logic [L-1:0]            iss_valid, iss_has_dst, iss_take, ren_valid, ren_a_rdy, ren_b_rdy;
  logic [L-1:0][4:0]       iss_dst, iss_src_a, iss_src_b;
  logic                    iss_full;
  logic [L-1:0][TW-1:0]    ren_dst_tag, ren_a_tag, ren_b_tag;
  logic [L-1:0][DW-1:0]    ren_a_val, ren_b_val;
  logic                    wb_valid, cmt_valid, cxl_valid;
  logic [TW-1:0]           wb_tag, cmt_tag, cxl_tag;
  logic [DW-1:0]           wb_data;

  rn_rename_unit #(.LANES(L), .ENTRIES(NE), .DW(DW)) dut_i (
    .clk(clk), .rst(rst), .indexed_mode(indexed_mode),
    .iss_valid(iss_valid), .iss_has_dst(iss_has_dst), .iss_dst(iss_dst),
    .iss_src_a(iss_src_a), .iss_src_b(iss_src_b), .iss_take(iss_take), .iss_full(iss_full),
    .ren_valid(ren_valid), .ren_dst_tag(ren_dst_tag),
    .ren_a_rdy(ren_a_rdy), .ren_a_tag(ren_a_tag), .ren_a_val(ren_a_val),
    .ren_b_rdy(ren_b_rdy), .ren_b_tag(ren_b_tag), .ren_b_val(ren_b_val),
    .wb_valid(wb_valid), .wb_tag(wb_tag), .wb_data(wb_data),
    .cmt_valid(cmt_valid), .cmt_tag(cmt_tag), .cxl_valid(cxl_valid), .cxl_tag(cxl_tag));

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string req, input string what, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s act=%0d exp=%0d", req, what, act, exp);
    end
  endtask

  // stimulus fields for the next cycle
  bit d_mode;
  bit d_iv[L], d_hd[L];
  int d_dst[L], d_sa[L], d_sb[L];
  bit d_wbv, d_cv, d_xv;
  int d_wbt, d_ct, d_xt;
  logic [DW-1:0] d_wbd;

  // reference state built from the requirements
  bit m_busy[NE], m_valid[NE], m_prevv[NE];
  int m_arch[NE], m_prev[NE];
  logic [DW-1:0] m_data[NE];
  logic [DW-1:0] m_rf[32];
  bit m_latv[32];
  int m_lat[32];

  typedef struct {
    int lane; bit hd; int dtag;
    bit ar; int at; logic [DW-1:0] av;
    bit br; int bt; logic [DW-1:0] bv;
    string req;
  } exp_t;
  exp_t q[$];

  task automatic clr();
    for (int i = 0; i < L; i++) begin
      d_iv[i] = 0; d_hd[i] = 0; d_dst[i] = 0; d_sa[i] = 0; d_sb[i] = 0;
    end
    d_wbv = 0; d_cv = 0; d_xv = 0; d_wbt = 0; d_ct = 0; d_xt = 0; d_wbd = '0;
  endtask

  task automatic lane(input int i, input bit hd, input int dst, input int sa, input int sb);
    d_iv[i] = 1; d_hd[i] = hd; d_dst[i] = dst; d_sa[i] = sa; d_sb[i] = sb;
  endtask

  task automatic exp_op(input int s, input int i, input bit tk[L], input int tg[L],
                        output bit rdy, output int tag, output logic [DW-1:0] val);
    bit g; int gt;
    g = 0; gt = 0;
    for (int j = 0; j < i; j++)
      if (tk[j] && d_hd[j] && d_dst[j] == s) begin g = 1; gt = tg[j]; end
    rdy = 1; tag = 0; val = '0;
    if (g) begin rdy = 0; tag = gt; end
    else if (m_latv[s]) begin
      if (m_valid[m_lat[s]]) val = m_data[m_lat[s]];
      else if (d_wbv && d_wbt == m_lat[s]) val = d_wbd;
      else begin rdy = 0; tag = m_lat[s]; end
    end else val = m_rf[s];
  endtask

  task automatic step(input string req);
    bit tk[L]; int tg[L]; bit e_full, blocked, clash; bit claimed[NE];
    int f, t, a; logic [L-1:0] e_take;
    exp_t it;
    e_full = 0; blocked = d_xv;
    for (int e = 0; e < NE; e++) claimed[e] = 0;
    for (int i = 0; i < L; i++) begin
      tk[i] = 0; tg[i] = 0;
      if (d_iv[i] && !blocked) begin
        if (!d_hd[i]) tk[i] = 1;
        else begin
          clash = 0;
          for (int j = 0; j < i; j++) if (tk[j] && d_hd[j] && d_dst[j] == d_dst[i]) clash = 1;
          if (d_mode && (clash || m_latv[d_dst[i]])) blocked = 1;
          else begin
            f = -1;
            for (int e = 0; e < NE; e++) if (f < 0 && !m_busy[e] && !claimed[e]) f = e;
            if (f < 0) begin blocked = 1; e_full = 1; end
            else begin claimed[f] = 1; tk[i] = 1; tg[i] = f; end
          end
        end
      end else if (d_iv[i]) blocked = 1;
    end
    @(negedge clk);
    indexed_mode = d_mode;
    for (int i = 0; i < L; i++) begin
      iss_valid[i] = d_iv[i]; iss_has_dst[i] = d_hd[i];
      iss_dst[i] = 5'(d_dst[i]); iss_src_a[i] = 5'(d_sa[i]); iss_src_b[i] = 5'(d_sb[i]);
      e_take[i] = tk[i];
    end
    wb_valid = d_wbv; wb_tag = TW'(d_wbt); wb_data = d_wbd;
    cmt_valid = d_cv; cmt_tag = TW'(d_ct); cxl_valid = d_xv; cxl_tag = TW'(d_xt);
    #1;
    chk(iss_take == e_take, req, "iss_take", iss_take, e_take);
    chk(iss_full == e_full, req, "iss_full", iss_full, e_full);
    for (int i = 0; i < L; i++) if (tk[i]) begin
      it.lane = i; it.hd = d_hd[i]; it.dtag = d_hd[i] ? tg[i] : 0; it.req = req;
      exp_op(d_sa[i], i, tk, tg, it.ar, it.at, it.av);
      exp_op(d_sb[i], i, tk, tg, it.br, it.bt, it.bv);
      q.push_back(it);
    end
    @(posedge clk);
    // model update: commit, cancel, write-back, new mappings
    if (d_cv) begin
      t = d_ct; a = m_arch[t];
      m_rf[a] = m_data[t];
      if (m_latv[a] && m_lat[a] == t) m_latv[a] = 0;
      m_busy[t] = 0; m_valid[t] = 0;
      for (int e = 0; e < NE; e++) if (m_prev[e] == t) m_prevv[e] = 0;
    end
    if (d_xv) begin
      t = d_xt; a = m_arch[t];
      if (m_latv[a] && m_lat[a] == t) begin
        if (m_prevv[t] && m_busy[m_prev[t]]) m_lat[a] = m_prev[t];
        else m_latv[a] = 0;
      end
      m_busy[t] = 0; m_valid[t] = 0;
      for (int e = 0; e < NE; e++) if (m_prev[e] == t) m_prevv[e] = 0;
    end
    if (d_wbv) begin m_valid[d_wbt] = 1; m_data[d_wbt] = d_wbd; end
    for (int i = 0; i < L; i++) if (tk[i] && d_hd[i]) begin
      t = tg[i]; a = d_dst[i];
      m_busy[t] = 1; m_valid[t] = 0; m_arch[t] = a;
      m_prev[t] = m_lat[a]; m_prevv[t] = m_latv[a];
      m_lat[a] = t; m_latv[a] = 1;
    end
    clr();
  endtask

  // monitor: compare rename results with the scoreboard
  always @(negedge clk) begin
    if (!rst) begin
      for (int i = 0; i < L; i++) if (ren_valid[i]) begin
        if (q.size() == 0) chk(0, "R3", "unexpected ren_valid lane", i, -1);
        else begin
          exp_t it;
          it = q.pop_front();
          chk(it.lane == i, it.req, "lane", i, it.lane);
          if (it.hd) chk(ren_dst_tag[i] == TW'(it.dtag), it.req, "dst_tag", ren_dst_tag[i], it.dtag);
          chk(ren_a_rdy[i] == it.ar, it.req, "a_rdy", ren_a_rdy[i], it.ar);
          chk(ren_a_tag[i] == TW'(it.at), it.req, "a_tag", ren_a_tag[i], it.at);
          chk(ren_a_val[i] == it.av, it.req, "a_val", ren_a_val[i], it.av);
          chk(ren_b_rdy[i] == it.br, it.req, "b_rdy", ren_b_rdy[i], it.br);
          chk(ren_b_tag[i] == TW'(it.bt), it.req, "b_tag", ren_b_tag[i], it.bt);
          chk(ren_b_val[i] == it.bv, it.req, "b_val", ren_b_val[i], it.bv);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      chk(0, "R1", "watchdog expired", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    for (int e = 0; e < NE; e++) begin m_busy[e]=0; m_valid[e]=0; m_prevv[e]=0; m_arch[e]=0; m_prev[e]=0; m_data[e]='0; end
    for (int r = 0; r < 32; r++) begin m_rf[r] = '0; m_latv[r] = 0; m_lat[r] = 0; end
    d_mode = 0; clr();
    rst = 1; indexed_mode = 0; iss_valid = '0; iss_has_dst = '0; iss_dst = '0;
    iss_src_a = '0; iss_src_b = '0; wb_valid = 0; wb_tag = '0; wb_data = '0;
    cmt_valid = 0; cmt_tag = '0; cxl_valid = 0; cxl_tag = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;
    #1;
    chk(iss_full == 0, "R1", "iss_full after reset", iss_full, 0);
    chk(ren_valid == '0, "R1", "ren_valid after reset", ren_valid, 0);

    lane(0, 0, 0, 5, 0); step("R1");                       // arch reads 0
    lane(0, 1, 1, 2, 3); lane(1, 1, 4, 1, 1); step("R4");  // r4 reads r1 from lane 0
    d_wbv = 1; d_wbt = 0; d_wbd = 100; lane(0, 0, 0, 1, 4); step("R6");
    lane(0, 1, 1, 0, 0); lane(1, 0, 0, 1, 3); step("R5");  // second live r1
    lane(0, 0, 0, 1, 4); step("R5");
    d_cv = 1; d_ct = 0; lane(0, 0, 0, 1, 4); step("R7");
    d_wbv = 1; d_wbt = 1; d_wbd = 7; step("R6");
    d_wbv = 1; d_wbt = 2; d_wbd = 55; step("R6");
    lane(0, 0, 0, 1, 4); step("R3");
    d_cv = 1; d_ct = 1; step("R7");
    d_cv = 1; d_ct = 2; step("R7");
    lane(0, 0, 0, 1, 4); step("R7");                       // both from arch: 55, 7

    lane(0, 1, 6, 0, 0); lane(1, 1, 6, 0, 0); step("R8");  // r6 -> 0, then 1
    d_wbv = 1; d_wbt = 1; d_wbd = 999; step("R8");
    d_xv = 1; d_xt = 1; step("R8");
    lane(0, 0, 0, 6, 6); step("R8");                       // back to older mapping
    d_xv = 1; d_xt = 0; step("R8");
    lane(0, 0, 0, 6, 1); step("R8");                       // arch r6 unchanged

    lane(0, 1, 7, 0, 0); step("R11");
    d_xv = 1; d_xt = 0; lane(0, 0, 0, 7, 7); lane(1, 1, 3, 0, 0); step("R11");
    lane(0, 0, 0, 7, 7); step("R11");

    for (int g = 0; g < 4; g++) begin
      lane(0, 1, 10 + 2*g, 0, 0); lane(1, 1, 11 + 2*g, 0, 0); step("R2");
    end
    lane(0, 1, 20, 0, 0); lane(1, 0, 0, 10, 0); step("R10");
    d_xv = 1; d_xt = 7; step("R10");
    lane(0, 1, 21, 17, 0); lane(1, 1, 22, 0, 0); step("R10");
    for (int t = 7; t >= 0; t--) begin d_xv = 1; d_xt = t; step("R8"); end

    d_mode = 1;
    lane(0, 1, 9, 0, 0); lane(1, 1, 9, 0, 0); step("R9");
    lane(0, 1, 9, 0, 0); step("R9");
    lane(0, 1, 8, 9, 0); lane(1, 1, 8, 0, 0); step("R9");
    lane(0, 0, 0, 9, 8); step("R9");
    repeat (3) step("R3");
    chk(q.size() == 0, "R3", "pending results", q.size(), 0);
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule